// File: doc/BRIEF.md
# Voted Syndrome Decoder for a Seven-Bit Code

This block performs the classical decoding step of error recovery for a logical bit held as a seven-bit code block, in which any single faulty bit can be repaired. For each error type it takes three successive measured ancilla words. It reduces each word to a 3-bit syndrome and takes a two-of-three vote across the three syndromes. The result is a one-hot mask that names the single data bit to flip, or no bit at all.

A strobe on `start_i` begins one recovery. A recovery is two passes in a fixed order: first for bit-flip errors, then for phase-flip errors. Each pass accepts three words over a valid/ready handshake and produces a one-cycle result with a type tag and two status flags. After the second result the block goes back to idle and waits for the next strobe.

Top module: `voted_syndrome_decoder`

## Requirements
- R1: The syndrome of a word is the XOR of (i+1), as a 3-bit value, over every set bit i of `word_i` (bit 0 is the least significant). A word with only bit i set therefore has syndrome i+1.
- R2: When at least two of the three syndromes in a pass are equal, that shared value becomes the agreed syndrome, whatever the third syndrome is.
- R3: An agreed syndrome of zero gives `res_mask_o` = 0, `res_clean_o` = 1 and `res_fail_o` = 0.
- R4: When all three syndromes differ, the result is `res_mask_o` = 0, `res_fail_o` = 1 and `res_clean_o` = 0.
- R5: A nonzero agreed syndrome s gives a mask with only bit s-1 set, with both flags at 0. A result mask never has more than one bit set.
- R6: The first result of a recovery has `res_phase_o` = 0 (bit-flip pass). The second has `res_phase_o` = 1 (phase-flip pass). `word_ready_o` stays high between the two passes.
- R7: `res_valid_o` is high for exactly one cycle: the cycle after the edge that accepts the third word of a pass. It is never high at any other time.
- R8: While idle, `word_ready_o` is 0 and offered words have no effect. A `start_i` pulse during a recovery is ignored.
- R9: After the second result, `word_ready_o` is 0 until the next `start_i`.
- R10: After reset, `word_ready_o` and `res_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a recovery when idle |
| word_valid_i | input | 1 | Ancilla word offered |
| word_i | input | 7 | Measured ancilla word |
| word_ready_o | output | 1 | Block accepts a word this cycle |
| res_valid_o | output | 1 | Result strobe, one cycle |
| res_mask_o | output | 7 | One-hot correction mask |
| res_phase_o | output | 1 | 0 = bit-flip pass, 1 = phase-flip pass |
| res_clean_o | output | 1 | Agreed syndrome was zero |
| res_fail_o | output | 1 | No two syndromes agreed |

## Verification
The bench sweeps all 512 ordered triples of syndromes. Each word carries a zero-syndrome codeword pattern, so a design that decoded raw bits instead of parity sums would name the wrong position. The sweep covers agreement between the first and third words and between the last two. A voter that only compared adjacent syndromes would report a failure on those cases, and one that preferred the third syndrome would return the outvoted value. The all-distinct and agreed-zero cases separate the two flags, so a design that swapped them or left a mask bit set is caught. Words offered while idle, a start strobe in the middle of a pass, and the idle state after the second pass are checked for a stray result, a restarted pass order or a handshake that never closes.

// File: rtl/vsd_pkg.sv
`timescale 1ns/1ps
package vsd_pkg;
  parameter int unsigned CODE_W    = 7;
  parameter int unsigned SYN_W     = $clog2(CODE_W + 1);
  parameter int unsigned NUM_VOTES = 3;
  localparam int unsigned CNT_W    = $clog2(NUM_VOTES);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BIT   = 2'd1,
    ST_PHASE = 2'd2
  } vsd_state_e;
endpackage

// File: rtl/vsd_syndrome.sv
`timescale 1ns/1ps
module vsd_syndrome #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned SYN_W  = 3
) (
  input  logic [CODE_W-1:0] word_i,
  output logic [SYN_W-1:0]  syn_o
);
  logic [SYN_W-1:0] col [CODE_W];

  // check-matrix column i holds the value i+1
  for (genvar i = 0; i < CODE_W; i++) begin : g_col
    assign col[i] = word_i[i] ? SYN_W'(i + 1) : '0;
  end

  always_comb begin
    syn_o = '0;
    for (int i = 0; i < CODE_W; i++) syn_o ^= col[i];
  end
endmodule

// File: rtl/vsd_vote.sv
`timescale 1ns/1ps
module vsd_vote #(
  parameter int unsigned SYN_W = 3
) (
  input  logic [SYN_W-1:0] syn_a_i,
  input  logic [SYN_W-1:0] syn_b_i,
  input  logic [SYN_W-1:0] syn_c_i,
  output logic [SYN_W-1:0] agreed_o,
  output logic             fail_o
);
  logic ab, ac, bc;
  assign ab = (syn_a_i == syn_b_i);
  assign ac = (syn_a_i == syn_c_i);
  assign bc = (syn_b_i == syn_c_i);

  always_comb begin
    fail_o   = 1'b0;
    agreed_o = '0;
    if (ab || ac)  agreed_o = syn_a_i;
    else if (bc)   agreed_o = syn_b_i;
    else           fail_o   = 1'b1;
  end
endmodule

// File: rtl/vsd_mask.sv
`timescale 1ns/1ps
module vsd_mask #(
  parameter int unsigned CODE_W = 7,
  parameter int unsigned SYN_W  = 3
) (
  input  logic [SYN_W-1:0]  syn_i,
  output logic [CODE_W-1:0] mask_o,
  output logic              zero_o
);
  for (genvar i = 0; i < CODE_W; i++) begin : g_bit
    assign mask_o[i] = (syn_i == SYN_W'(i + 1));
  end
  assign zero_o = (syn_i == '0);
endmodule

// File: rtl/voted_syndrome_decoder.sv
`timescale 1ns/1ps
module voted_syndrome_decoder
  import vsd_pkg::*;
#(
  parameter int unsigned CODE_W = vsd_pkg::CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              word_valid_i,
  input  logic [CODE_W-1:0] word_i,
  output logic              word_ready_o,
  output logic              res_valid_o,
  output logic [CODE_W-1:0] res_mask_o,
  output logic              res_phase_o,
  output logic              res_clean_o,
  output logic              res_fail_o
);
  localparam int unsigned SW = $clog2(CODE_W + 1);
  localparam int unsigned LAST = NUM_VOTES - 1;

  vsd_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SW-1:0]    syn_q [LAST];
  logic [SW-1:0]    cur_syn, agreed;
  logic             vote_fail, agreed_zero, accept;
  logic [CODE_W-1:0] dec_mask;

  vsd_syndrome #(.CODE_W(CODE_W), .SYN_W(SW)) u_syn (
    .word_i (word_i),
    .syn_o  (cur_syn)
  );

  vsd_vote #(.SYN_W(SW)) u_vote (
    .syn_a_i  (syn_q[0]),
    .syn_b_i  (syn_q[1]),
    .syn_c_i  (cur_syn),
    .agreed_o (agreed),
    .fail_o   (vote_fail)
  );

  vsd_mask #(.CODE_W(CODE_W), .SYN_W(SW)) u_mask (
    .syn_i  (agreed),
    .mask_o (dec_mask),
    .zero_o (agreed_zero)
  );

  assign word_ready_o = (state_q != ST_IDLE);
  assign accept       = word_valid_i && word_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      res_valid_o <= 1'b0;
      res_mask_o  <= '0;
      res_phase_o <= 1'b0;
      res_clean_o <= 1'b0;
      res_fail_o  <= 1'b0;
      for (int i = 0; i < LAST; i++) syn_q[i] <= '0;
    end else begin
      res_valid_o <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          state_q <= ST_BIT;
          cnt_q   <= '0;
        end
      end else if (accept) begin
        if (cnt_q != CNT_W'(LAST)) begin
          syn_q[cnt_q] <= cur_syn;
          cnt_q        <= cnt_q + 1'b1;
        end else begin
          cnt_q       <= '0;
          res_valid_o <= 1'b1;
          res_mask_o  <= vote_fail ? '0 : dec_mask;
          res_clean_o <= !vote_fail && agreed_zero;
          res_fail_o  <= vote_fail;
          res_phase_o <= (state_q == ST_PHASE);
          state_q     <= (state_q == ST_BIT) ? ST_PHASE : ST_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/voted_syndrome_decoder_chk.sv
`timescale 1ns/1ps
module voted_syndrome_decoder_chk #(
  parameter int unsigned CODE_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_ready_o,
  input logic              res_valid_o,
  input logic [CODE_W-1:0] res_mask_o,
  input logic              res_phase_o,
  input logic              res_clean_o,
  input logic              res_fail_o
);
  assert_mask_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $onehot0(res_mask_o));

  assert_clean_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_clean_o) |-> (res_mask_o == '0 && !res_fail_o));

  assert_fail_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_fail_o) |-> (res_mask_o == '0 && !res_clean_o));

  assert_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  assert_between_passes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_phase_o) |-> word_ready_o);

  assert_idle_after_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_phase_o) |-> !word_ready_o);
endmodule

bind voted_syndrome_decoder voted_syndrome_decoder_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_ready_o (word_ready_o),
  .res_valid_o  (res_valid_o),
  .res_mask_o   (res_mask_o),
  .res_phase_o  (res_phase_o),
  .res_clean_o  (res_clean_o),
  .res_fail_o   (res_fail_o)
);

// File: tb/voted_syndrome_decoder_tb.sv
`timescale 1ns/1ps
module voted_syndrome_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       wvalid = 1'b0;
  logic [6:0] word = '0;
  logic       wready, rvalid, rphase, rclean, rfail;
  logic [6:0] rmask;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  voted_syndrome_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .word_valid_i(wvalid), .word_i(word), .word_ready_o(wready),
    .res_valid_o(rvalid), .res_mask_o(rmask), .res_phase_o(rphase),
    .res_clean_o(rclean), .res_fail_o(rfail)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int syn_of(logic [6:0] w);
    int s = 0;
    for (int i = 0; i < 7; i++) if (w[i]) s ^= (i + 1);
    return s;
  endfunction

  // word with syndrome s, disguised by a zero-syndrome pattern
  function automatic logic [6:0] word_for(int s, int k);
    logic [6:0] base = (s == 0) ? 7'h00 : 7'(1 << (s - 1));
    logic [6:0] pad;
    case (k % 4)
      0: pad = 7'h00;
      1: pad = 7'h07;
      2: pad = 7'h19;
      default: pad = 7'h1e;
    endcase
    return base ^ pad;
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(logic [6:0] w, bit with_start);
    wvalid = 1'b1;
    word = w;
    start = with_start;
    @(negedge clk);
    wvalid = 1'b0;
    start = 1'b0;
  endtask

  task automatic run_pass(int a, int b, int c, int k, int phase, bit mid_start);
    int agreed, fail;
    logic [6:0] emask;
    chk("R6 ready during pass", wready, 1);
    send(word_for(a, k), mid_start);
    send(word_for(b, k + 1), 1'b0);
    chk("R7 no early result", rvalid, 0);
    send(word_for(c, k + 2), 1'b0);
    fail = 0;
    if (a == b || a == c) agreed = a;
    else if (b == c) agreed = b;
    else begin agreed = 0; fail = 1; end
    emask = (fail || agreed == 0) ? 7'h00 : 7'(1 << (agreed - 1));
    chk("R7 result valid", rvalid, 1);
    chk("R2 R5 mask", rmask, emask);
    chk("R3 clean flag", rclean, (!fail && agreed == 0) ? 1 : 0);
    chk("R4 fail flag", rfail, fail);
    chk("R6 pass type", rphase, phase);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ready after reset", wready, 0);
    chk("R10 valid after reset", rvalid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready idle", wready, 0);

    // R1: single-bit words map to position+1, codeword pads map to zero
    for (int i = 0; i < 7; i++) chk("R1 bench syndrome", syn_of(word_for(i + 1, i)), i + 1);

    // R8: words offered while idle are ignored
    for (int j = 0; j < 3; j++) begin
      send(7'h01 << j, 1'b0);
      chk("R8 ready low idle", wready, 0);
      chk("R8 no result idle", rvalid, 0);
    end

    // sweep of all syndrome triples
    for (int n = 0; n < 512; n++) begin
      int a = n % 8, b = (n / 8) % 8, c = n / 64;
      pulse_start();
      run_pass(a, b, c, n, 0, 1'b0);
      run_pass(c, a, b, n + 1, 1, (n % 16) == 0);  // R8 start mid-pass
      chk("R9 ready low after recovery", wready, 0);
      @(negedge clk);
      chk("R7 single-cycle pulse", rvalid, 0);
      chk("R9 still idle", wready, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule